// File: doc/BRIEF.md
# Dual Byte Buffer with Threshold Interrupts

This block holds two byte queues of 64 entries each. The host fills the transmit queue through a register port, and the radio side drains it one byte per `tx_pop`. The radio side fills the receive queue one byte per `rx_push`, and the host drains it by reading a data register. Each queue compares its live byte count against programmable 6-bit levels. The transmit queue has a high level and a low level. The receive queue has a high level. When a level is met, a sticky status bit is set.

Bad accesses also set sticky bits: a host write into a full transmit queue, and a host read from an empty receive queue. Every status bit has its own enable bit. The active-low `irq_n` line goes low when any enabled status bit is set. Reading the status register returns its value and clears it in the same access. Writing to the control register empties either queue at once. The control register has no storage and always reads as zero.

Register port addresses (4-bit `bus_addr`):

| Address | Register |
|---|---|
| 0 | control: bit0 empties the transmit queue, bit1 empties the receive queue |
| 1 | transmit high level |
| 2 | transmit low level |
| 3 | receive high level |
| 4 | enable mask |
| 5 | status |
| 6 | transmit data (write) |
| 7 | receive data (read) |
| 8 | transmit count |
| 9 | receive count |

Status and enable bits:

| Bit | Meaning |
|---|---|
| 0 | transmit high |
| 1 | transmit low |
| 2 | receive high |
| 3 | transmit overflow |
| 4 | receive underflow |

Read data on `bus_rdata` is combinational for the address presented. A read takes effect at the clock edge that ends it.

Top module: `byte_fifo_pair_irq`

## Requirements
- R1: After reset, the transmit high level (address 1) and the receive high level (address 3) read 0x37, and the transmit low level (address 2) reads 0x04. The enable mask reads 0, both counts read 0, `tx_avail` is 0 and `irq_n` is 1.
- R2: Bytes written to address 6 appear on `tx_data` in the order they were written. Each `tx_pop` advances to the next byte. `tx_avail` is 1 while the transmit count is not zero.
- R3: Bytes pushed with `rx_push` are returned in arrival order by reads of address 7. Address 9 reports the number held.
- R4: Status bit 2 sets when the receive count is greater than or equal to the receive high level.
- R5: Status bit 0 sets when the transmit count is greater than or equal to the transmit high level. Status bit 1 sets when the transmit count is less than or equal to the transmit low level.
- R6: Status bits stay set until the host reads address 5. That read returns the bits and then clears them. A level condition that still holds sets its bit again on the next cycle.
- R7: A write to address 6 while the transmit queue holds 64 bytes is dropped. The count stays 64, the stored bytes are unchanged, and status bit 3 sets.
- R8: A read of address 7 while the receive queue is empty returns 0x00, leaves the count at 0 and sets status bit 4.
- R9: Writing 1 to control bit0 empties the transmit queue, and writing 1 to control bit1 empties the receive queue. The emptying takes effect at the edge of that write. Address 0 reads 0.
- R10: `irq_n` is low exactly when some status bit is set with its enable bit set. A status bit that is not enabled still sets and reads correctly.
- R11: A `tx_pop` on an empty transmit queue, and an `rx_push` on a full receive queue, are ignored. Neither changes the count or the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 4 | register address |
| bus_wr | input | 1 | register write strobe |
| bus_wdata | input | 8 | register write data |
| bus_rd | input | 1 | register read strobe; pops receive data, clears status |
| bus_rdata | output | 8 | register read data |
| tx_pop | input | 1 | consume the head transmit byte |
| tx_data | output | 8 | head transmit byte |
| tx_avail | output | 1 | transmit queue not empty |
| rx_push | input | 1 | store `rx_data` in the receive queue |
| rx_data | input | 8 | incoming receive byte |
| irq_n | output | 1 | active-low interrupt |

## Verification
A wrong pointer or count shows up at the ports as soon as the next byte leaves a queue. A bad pointer puts the wrong value on `tx_data`, or returns the wrong value from address 7. A drifting count shows on the count registers, and one cycle later as a level flag at the wrong fill. A status bit that clears by itself, or one that will not clear, is seen on the next status read. A masking fault shows on `irq_n` one cycle after the event that should, or should not, pull it low.

// File: rtl/byte_fifo_pair_irq.sv
module byte_fifo_pair_irq #(
  parameter int DEPTH = 64,
  parameter int THR_W = 6,
  parameter logic [THR_W-1:0] HI_RST = 6'h37,
  parameter logic [THR_W-1:0] LO_RST = 6'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       tx_pop,
  output logic [7:0] tx_data,
  output logic       tx_avail,
  input  logic       rx_push,
  input  logic [7:0] rx_data,
  output logic       irq_n
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam int NS = 5;
  localparam logic [3:0] A_CTRL = 4'd0, A_TXHI = 4'd1, A_TXLO = 4'd2, A_RXHI = 4'd3,
                         A_IEN = 4'd4, A_STAT = 4'd5, A_TXD = 4'd6, A_RXD = 4'd7,
                         A_TXC = 4'd8, A_RXC = 4'd9;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [THR_W-1:0] tx_hi, tx_lo, rx_hi;
  logic [NS-1:0] ien, status, set_now;

  wire cfg_wr  = bus_wr;
  wire clr_tx  = cfg_wr && bus_addr == A_CTRL && bus_wdata[0];
  wire clr_rx  = cfg_wr && bus_addr == A_CTRL && bus_wdata[1];
  wire tx_wreq = cfg_wr && bus_addr == A_TXD;
  wire rx_rreq = bus_rd && bus_addr == A_RXD;
  wire rd_stat = bus_rd && bus_addr == A_STAT;
  wire tx_in   = tx_wreq && tx_cnt != FULL;
  wire tx_out  = tx_pop && tx_cnt != '0;
  wire rx_in   = rx_push && rx_cnt != FULL;
  wire rx_out  = rx_rreq && rx_cnt != '0;

  assign set_now = {rx_rreq && rx_cnt == '0,
                    tx_wreq && tx_cnt == FULL,
                    rx_cnt >= CW'(rx_hi),
                    tx_cnt <= CW'(tx_lo),
                    tx_cnt >= CW'(tx_hi)};

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= bus_wdata;
    if (rx_in) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in) tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in) rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hi <= HI_RST; tx_lo <= LO_RST; rx_hi <= HI_RST;
      ien <= '0; status <= '0;
    end else begin
      if (cfg_wr && bus_addr == A_TXHI) tx_hi <= bus_wdata[THR_W-1:0];
      if (cfg_wr && bus_addr == A_TXLO) tx_lo <= bus_wdata[THR_W-1:0];
      if (cfg_wr && bus_addr == A_RXHI) rx_hi <= bus_wdata[THR_W-1:0];
      if (cfg_wr && bus_addr == A_IEN)  ien   <= bus_wdata[NS-1:0];
      status <= set_now | (rd_stat ? '0 : status);
    end
  end

  assign tx_data  = tx_mem[tx_rp];
  assign tx_avail = tx_cnt != '0;
  assign irq_n    = ~|(status & ien);

  always_comb begin
    case (bus_addr)
      A_TXHI:  bus_rdata = 8'(tx_hi);
      A_TXLO:  bus_rdata = 8'(tx_lo);
      A_RXHI:  bus_rdata = 8'(rx_hi);
      A_IEN:   bus_rdata = 8'(ien);
      A_STAT:  bus_rdata = 8'(status);
      A_RXD:   bus_rdata = rx_cnt != '0 ? rx_mem[rx_rp] : 8'h00;
      A_TXC:   bus_rdata = 8'(tx_cnt);
      A_RXC:   bus_rdata = 8'(rx_cnt);
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL && rx_cnt <= FULL); // R11
  AST_CLEAR_TX: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tx |=> tx_cnt == '0); // R9
  AST_CLEAR_RX: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rx |=> rx_cnt == '0); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wreq && tx_cnt == FULL && !tx_pop |=> tx_cnt == FULL && status[3]); // R7
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rreq && rx_cnt == '0 |=> status[4]); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ($past(status) & ~status) == '0); // R6
  AST_RX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt >= CW'(rx_hi) |=> status[2]); // R4
endmodule

// File: tb/byte_fifo_pair_irq_test.sv
module byte_fifo_pair_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 0, A_TXHI = 1, A_TXLO = 2, A_RXHI = 3, A_IEN = 4,
                         A_STAT = 5, A_TXD = 6, A_RXD = 7, A_TXC = 8, A_RXC = 9;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, tx_pop = 0, rx_push = 0;
  logic [7:0] bus_wdata = 0, rx_data = 0;
  logic [7:0] bus_rdata, tx_data;
  logic tx_avail, irq_n;
  int n_chk = 0, n_fail = 0;

  byte_fifo_pair_irq uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_avail(tx_avail), .rx_push(rx_push), .rx_data(rx_data),
    .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #(CLK_PERIOD/4); d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic fresh();
    logic [7:0] v;
    wr(A_CTRL, 8'h03); idle(); rd(A_STAT, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_TXHI, v); check("R1 tx high", v, 8'h37);
    rd(A_TXLO, v); check("R1 tx low", v, 8'h04);
    rd(A_RXHI, v); check("R1 rx high", v, 8'h37);
    rd(A_IEN, v);  check("R1 enable", v, 0);
    rd(A_TXC, v);  check("R1 tx count", v, 0);
    rd(A_RXC, v);  check("R1 rx count", v, 0);
    check("R1 tx_avail", tx_avail, 0);
    check("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_tx_order();
    fresh();
    wr(A_TXD, 8'hA1); wr(A_TXD, 8'hB2); wr(A_TXD, 8'hC3);
    check("R2 avail", tx_avail, 1);
    check("R2 head0", tx_data, 8'hA1); pop();
    check("R2 head1", tx_data, 8'hB2); pop();
    check("R2 head2", tx_data, 8'hC3); pop();
    check("R2 drained", tx_avail, 0);
  endtask

  task automatic t_rx_order();
    logic [7:0] v;
    fresh();
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
    rd(A_RXC, v); check("R3 count", v, 5);
    for (int i = 0; i < 5; i++) begin
      rd(A_RXD, v); check("R3 order", v, 8'h10 + i);
    end
    rd(A_RXC, v); check("R3 empty", v, 0);
  endtask

  task automatic t_rx_high();
    logic [7:0] v;
    fresh(); wr(A_RXHI, 8'd4);
    for (int i = 0; i < 3; i++) push(8'(i));
    idle(); rd(A_STAT, v); check("R4 below", v[2], 0);
    push(8'h03); idle();
    rd(A_STAT, v); check("R4 reached", v[2], 1);
    idle(); rd(A_STAT, v); check("R6 level re-set", v[2], 1);
    for (int i = 0; i < 4; i++) rd(A_RXD, v);
    idle(); rd(A_STAT, v); idle();
    rd(A_STAT, v); check("R6 cleared", v[2], 0);
  endtask

  task automatic t_tx_levels();
    logic [7:0] v;
    fresh(); wr(A_TXHI, 8'd8); wr(A_TXLO, 8'd2);
    for (int i = 0; i < 3; i++) wr(A_TXD, 8'(i));
    idle(); rd(A_STAT, v); idle();
    rd(A_STAT, v); check("R5 low off", v[1], 0);
    check("R5 high off", v[0], 0);
    for (int i = 0; i < 5; i++) wr(A_TXD, 8'(i));
    idle(); rd(A_STAT, v); check("R5 high on", v[0], 1);
    wr(A_CTRL, 8'h01); idle();
    rd(A_STAT, v); check("R5 low on", v[1], 1);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    fresh();
    for (int i = 0; i < 64; i++) wr(A_TXD, 8'(i + 1));
    rd(A_STAT, v); check("R7 no flag yet", v[3], 0);
    wr(A_TXD, 8'hEE);
    rd(A_TXC, v); check("R7 count", v, 64);
    rd(A_STAT, v); check("R7 flag", v[3], 1);
    check("R7 head kept", tx_data, 8'h01);
    rd(A_STAT, v); check("R6 event cleared", v[3], 0);
  endtask

  task automatic t_underflow();
    logic [7:0] v;
    fresh();
    rd(A_RXD, v); check("R8 data", v, 0);
    rd(A_RXC, v); check("R8 count", v, 0);
    rd(A_STAT, v); check("R8 flag", v[4], 1);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    fresh();
    for (int i = 0; i < 3; i++) begin push(8'(i)); wr(A_TXD, 8'(i)); end
    wr(A_CTRL, 8'h01);
    rd(A_TXC, v); check("R9 tx cleared", v, 0);
    rd(A_RXC, v); check("R9 rx kept", v, 3);
    wr(A_CTRL, 8'h02);
    rd(A_RXC, v); check("R9 rx cleared", v, 0);
    rd(A_CTRL, v); check("R9 ctrl reads 0", v, 0);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    fresh(); wr(A_IEN, 8'h00);
    rd(A_RXD, v);
    check("R10 masked irq", irq_n, 1);
    rd(A_STAT, v); check("R10 masked status", v[4], 1);
    wr(A_IEN, 8'h10);
    check("R10 idle irq", irq_n, 1);
    rd(A_RXD, v);
    check("R10 irq low", irq_n, 0);
    rd(A_STAT, v);
    check("R10 irq released", irq_n, 1);
    wr(A_IEN, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    fresh();
    pop();
    rd(A_TXC, v); check("R11 tx pop empty", v, 0);
    for (int i = 0; i < 64; i++) push(8'(i + 1));
    push(8'hFF);
    rd(A_RXC, v); check("R11 rx full count", v, 64);
    for (int i = 0; i < 63; i++) rd(A_RXD, v);
    rd(A_RXD, v); check("R11 last byte", v, 64);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx_order();
    t_rx_order();
    t_rx_high();
    t_tx_levels();
    t_overflow();
    t_underflow();
    t_clear();
    t_irq();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule